// File: doc/BRIEF.md
# Mailbox Receive Overrun Status Tracker

This block holds the per-mailbox reception status of a 16-mailbox message controller. For each mailbox it keeps a data-frame pending flag, a remote-frame pending flag and an unread flag. The unread flag records that a frame was received and overwrote the previous one before software had acknowledged it. The reception engine signals a completed frame with a one-cycle event for the target mailbox and a frame-type bit. A per-mailbox direction vector marks the mailboxes that are set up for transmission.

Software reaches the state through a small register port with a 2-bit address. The three status registers are cleared by writing 1 to a bit. A fourth register is a plain read/write interrupt mask. One level-sensitive interrupt request goes high while any unmasked unread flag is set. The three status vectors are also driven out in parallel for neighbouring logic.

Top module: `mbx_rx_overrun_tracker`

## Requirements
- R1: After reset the data-pending, remote-pending, unread and mask registers are all zero, and `irq` is low.
- R2: A reception event with `rx_remote`=0 sets that mailbox's data-pending bit. With `rx_remote`=1 it sets that mailbox's remote-pending bit. Events on several mailboxes in one cycle act independently.
- R3: The unread bit of a receive mailbox (`mbx_is_tx`=0) becomes 1 when a frame of either type arrives while its data-pending or remote-pending bit was already 1 before that frame. A frame into a mailbox with both pending bits 0 leaves the unread bit at 0.
- R4: For a transmit mailbox (`mbx_is_tx`=1), a data-frame event changes nothing, and the unread bit is never set by any event. A remote-frame event still sets its remote-pending bit.
- R5: A write to address 0 (data-pending), 1 (remote-pending) or 2 (unread) clears every bit where the write data holds 1. Bits written with 0 keep their value.
- R6: When a hardware set and a write-1 clear hit the same bit in the same cycle, the bit ends at 1.
- R7: A write to address 3 loads the interrupt mask, where 1 masks a mailbox. `irq` is 1 exactly when some mailbox has its unread bit 1 and its mask bit 0.
- R8: `cpu_rdata` returns data-pending at address 0, remote-pending at 1, unread at 2 and mask at 3. Reading changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_evt | input | 16 | One-cycle frame-received strobe per mailbox |
| rx_remote | input | 16 | Frame type per mailbox: 1 remote, 0 data |
| mbx_is_tx | input | 16 | Mailbox direction: 1 transmit, 0 receive |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register select |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data of the selected register |
| data_pend | output | 16 | Data-frame pending flags |
| rmt_pend | output | 16 | Remote-frame pending flags |
| unread | output | 16 | Overwritten-message flags |
| irq | output | 1 | Interrupt request |

## Verification
A wrong pending bit is not always visible right away. It first shows on `data_pend` or `rmt_pend` one cycle after the event. If the bit is stale, the error surfaces later as a missing or spurious `unread` bit one cycle after the next frame to that mailbox. A wrong unread or mask bit shows on `irq` in the same cycle the register updates. The bench therefore compares every output against a reference model after every clock, so a divergence is caught at the first edge where it becomes observable.

// File: rtl/mbx_status_pkg.sv
package mbx_status_pkg;
    localparam int unsigned NUM_MBX    = 16;
    localparam int unsigned ADDR_W     = 2;
    localparam logic [1:0]  A_DATA     = 2'd0;
    localparam logic [1:0]  A_RMT      = 2'd1;
    localparam logic [1:0]  A_UNREAD   = 2'd2;
    localparam logic [1:0]  A_MASK     = 2'd3;

    typedef struct packed {
        logic data;
        logic rmt;
        logic unread;
    } mbx_bits_t;
endpackage

// File: rtl/mbx_status_slice.sv
module mbx_status_slice
    import mbx_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_evt,
    input  logic rx_remote,
    input  logic is_tx,
    input  logic clr_data,
    input  logic clr_rmt,
    input  logic clr_unread,
    output logic data_o,
    output logic rmt_o,
    output logic unread_o
);
    mbx_bits_t st_d, st_q;
    logic set_data, set_rmt, set_unread;

    always_comb begin
        set_data   = rx_evt && !rx_remote && !is_tx;
        set_rmt    = rx_evt && rx_remote;
        set_unread = rx_evt && !is_tx && (st_q.data || st_q.rmt);
        st_d = st_q;
        if (clr_data)   st_d.data   = 1'b0;
        if (clr_rmt)    st_d.rmt    = 1'b0;
        if (clr_unread) st_d.unread = 1'b0;
        if (set_data)   st_d.data   = 1'b1;
        if (set_rmt)    st_d.rmt    = 1'b1;
        if (set_unread) st_d.unread = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o   = st_q.data;
    assign rmt_o    = st_q.rmt;
    assign unread_o = st_q.unread;

    p_data_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt && !rx_remote && !is_tx) |=> data_o);
    p_rmt_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt && rx_remote) |=> rmt_o);
    p_unread_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unread_o) |-> $past(rx_evt && (data_o || rmt_o)));
    p_tx_no_unread_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unread_o) |-> $past(!is_tx));
    p_zero_write_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (unread_o && !clr_unread) |=> unread_o);
    p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt && !is_tx && (data_o || rmt_o) && clr_unread) |=> unread_o);
endmodule

// File: rtl/mbx_irq_reduce.sv
module mbx_irq_reduce #(
    parameter int unsigned N = 16
) (
    input  logic [N-1:0] unread,
    input  logic [N-1:0] mask,
    output logic         irq
);
    assign irq = |(unread & ~mask);
endmodule

// File: rtl/mbx_rx_overrun_tracker.sv
module mbx_rx_overrun_tracker
    import mbx_status_pkg::*;
#(
    parameter int unsigned N_MBX = NUM_MBX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_MBX-1:0]  rx_evt,
    input  logic [N_MBX-1:0]  rx_remote,
    input  logic [N_MBX-1:0]  mbx_is_tx,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [N_MBX-1:0]  cpu_wdata,
    output logic [N_MBX-1:0]  cpu_rdata,
    output logic [N_MBX-1:0]  data_pend,
    output logic [N_MBX-1:0]  rmt_pend,
    output logic [N_MBX-1:0]  unread,
    output logic              irq
);
    logic [N_MBX-1:0] clr_data, clr_rmt, clr_unread;
    logic [N_MBX-1:0] mask_d, mask_q;

    always_comb begin
        clr_data   = (cpu_wr && cpu_addr == A_DATA)   ? cpu_wdata : '0;
        clr_rmt    = (cpu_wr && cpu_addr == A_RMT)    ? cpu_wdata : '0;
        clr_unread = (cpu_wr && cpu_addr == A_UNREAD) ? cpu_wdata : '0;
        mask_d     = (cpu_wr && cpu_addr == A_MASK)   ? cpu_wdata : mask_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    for (genvar g = 0; g < N_MBX; g++) begin : g_mbx
        mbx_status_slice u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .rx_evt     (rx_evt[g]),
            .rx_remote  (rx_remote[g]),
            .is_tx      (mbx_is_tx[g]),
            .clr_data   (clr_data[g]),
            .clr_rmt    (clr_rmt[g]),
            .clr_unread (clr_unread[g]),
            .data_o     (data_pend[g]),
            .rmt_o      (rmt_pend[g]),
            .unread_o   (unread[g])
        );
    end

    mbx_irq_reduce #(.N(N_MBX)) u_irq (
        .unread (unread),
        .mask   (mask_q),
        .irq    (irq)
    );

    always_comb begin
        unique case (cpu_addr)
            A_DATA:   cpu_rdata = data_pend;
            A_RMT:    cpu_rdata = rmt_pend;
            A_UNREAD: cpu_rdata = unread;
            default:  cpu_rdata = mask_q;
        endcase
    end

    p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_addr == A_MASK) |=> $stable(mask_q));
    p_irq_needs_unread_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (unread != '0));
endmodule

// File: tb/mbx_rx_overrun_tracker_tb_top.sv
module mbx_rx_overrun_tracker_tb_top;
    localparam int N = 16;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] rx_evt = '0, rx_remote = '0, mbx_is_tx = '0, cpu_wdata = '0;
    logic cpu_wr = 1'b0;
    logic [1:0] cpu_addr = '0;
    logic [N-1:0] cpu_rdata, data_pend, rmt_pend, unread;
    logic irq;

    logic [N-1:0] md, mr, mu, mm;
    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    mbx_rx_overrun_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .rx_remote(rx_remote),
        .mbx_is_tx(mbx_is_tx), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .data_pend(data_pend),
        .rmt_pend(rmt_pend), .unread(unread), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic exp_irq();
        return |(mu & ~mm);
    endfunction

    function automatic logic [N-1:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return md;
            2'd1: return mr;
            2'd2: return mu;
            default: return mm;
        endcase
    endfunction

    task automatic model_step();
        logic [N-1:0] sd, sr, su, cd, cr, cu;
        sd = rx_evt & ~rx_remote & ~mbx_is_tx;
        sr = rx_evt & rx_remote;
        su = rx_evt & ~mbx_is_tx & (md | mr);
        cd = (cpu_wr && cpu_addr == 2'd0) ? cpu_wdata : '0;
        cr = (cpu_wr && cpu_addr == 2'd1) ? cpu_wdata : '0;
        cu = (cpu_wr && cpu_addr == 2'd2) ? cpu_wdata : '0;
        md = (md & ~cd) | sd;
        mr = (mr & ~cr) | sr;
        mu = (mu & ~cu) | su;
        if (cpu_wr && cpu_addr == 2'd3) mm = cpu_wdata;
    endtask

    task automatic check_all(input string req);
        chk({req, " data_pend"}, 32'(data_pend), 32'(md));
        chk({req, " rmt_pend"}, 32'(rmt_pend), 32'(mr));
        chk({req, " unread"}, 32'(unread), 32'(mu));
        chk({req, " irq"}, 32'(irq), 32'(exp_irq()));
        chk({req, " rdata"}, 32'(cpu_rdata), 32'(exp_read(cpu_addr)));
    endtask

    task automatic step(input logic [N-1:0] e, input logic [N-1:0] r, input logic [N-1:0] t,
                        input logic w, input logic [1:0] a, input logic [N-1:0] wd,
                        input string req);
        @(negedge clk);
        rx_evt = e; rx_remote = r; mbx_is_tx = t;
        cpu_wr = w; cpu_addr = a; cpu_wdata = wd;
        @(posedge clk);
        model_step();
        #1;
        rx_evt = '0; cpu_wr = 1'b0;
        #0.5;
        check_all(req);
    endtask

    task automatic read_chk(input logic [1:0] a, input string req);
        @(negedge clk);
        rx_evt = '0; cpu_wr = 1'b0; cpu_addr = a;
        #1;
        chk({req, " read"}, 32'(cpu_rdata), 32'(exp_read(a)));
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1357));
        md = '0; mr = '0; mu = '0; mm = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 4; a++) read_chk(2'(a), "R1");
        chk("R1 irq", 32'(irq), 32'd0);

        // R2 and R3: first data frame into empty mailbox 3
        step(16'h0008, 16'h0000, 16'h0000, 1'b0, 2'd0, '0, "R2");
        chk("R3 first frame no unread", 32'(unread[3]), 32'd0);
        // R3: second frame overwrites
        step(16'h0008, 16'h0000, 16'h0000, 1'b0, 2'd2, '0, "R3");
        chk("R3 overwrite sets unread", 32'(unread[3]), 32'd1);
        chk("R7 irq with unmasked unread", 32'(irq), 32'd1);
        // R3 through remote pending: mailbox 5
        step(16'h0020, 16'h0020, 16'h0000, 1'b0, 2'd1, '0, "R2");
        chk("R2 remote pend", 32'(rmt_pend[5]), 32'd1);
        step(16'h0020, 16'h0000, 16'h0000, 1'b0, 2'd0, '0, "R3");
        chk("R3 via remote pend", 32'(unread[5]), 32'd1);
        // R4: transmit mailbox 7
        step(16'h0080, 16'h0000, 16'h0080, 1'b0, 2'd0, '0, "R4");
        chk("R4 tx data ignored", 32'(data_pend[7]), 32'd0);
        step(16'h0080, 16'h0080, 16'h0080, 1'b0, 2'd1, '0, "R4");
        step(16'h0080, 16'h0080, 16'h0080, 1'b0, 2'd2, '0, "R4");
        chk("R4 tx never unread", 32'(unread[7]), 32'd0);
        chk("R4 tx remote pend", 32'(rmt_pend[7]), 32'd1);
        // R5: zero write keeps, one write clears
        step('0, '0, '0, 1'b1, 2'd2, 16'h0000, "R5");
        chk("R5 zero write keeps", 32'(unread), 32'h0028);
        step('0, '0, '0, 1'b1, 2'd2, 16'h0008, "R5");
        chk("R5 one write clears", 32'(unread), 32'h0020);
        step('0, '0, '0, 1'b1, 2'd0, 16'h0008, "R5");
        chk("R5 data clear", 32'(data_pend[3]), 32'd0);
        // R6: set beats clear on mailbox 5
        step(16'h0020, 16'h0000, 16'h0000, 1'b1, 2'd2, 16'h0020, "R6");
        chk("R6 unread survives clear", 32'(unread[5]), 32'd1);
        step(16'h0020, 16'h0000, 16'h0000, 1'b1, 2'd0, 16'h0020, "R6");
        chk("R6 data survives clear", 32'(data_pend[5]), 32'd1);
        // R7: masking
        step('0, '0, '0, 1'b1, 2'd3, 16'h0020, "R7");
        chk("R7 masked irq low", 32'(irq), 32'd0);
        step('0, '0, '0, 1'b1, 2'd3, 16'h0000, "R7");
        chk("R7 unmasked irq high", 32'(irq), 32'd1);
        // R8: reads have no side effect
        for (int a = 0; a < 4; a++) read_chk(2'(a), "R8");
        for (int a = 0; a < 4; a++) read_chk(2'(a), "R8 repeat");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [N-1:0] e, r, t, wd;
            logic w;
            logic [1:0] a;
            e  = N'($urandom & $urandom);
            r  = N'($urandom);
            t  = N'($urandom & $urandom & $urandom);
            w  = ($urandom % 3) == 0;
            a  = 2'($urandom);
            wd = N'($urandom);
            step(e, r, t, w, a, wd, "R2 R3 R4 R5 R6 R7 random");
        end
        read_chk(2'd3, "R8 final");
        finish_run();
    end
endmodule